// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Gain Ramp

This block fades a stereo sample stream in and out without clicks. Each left and right sample is multiplied by a shared gain. The gain does not jump between full level and silence. When a mute is requested it falls along a raised-cosine curve from unity to zero, and when the mute is released it climbs back the same way. A complete fade takes 32 gain steps, and each step is held for 32 samples, so a fade spans 1024 input samples.

The mute request comes from one of two places, chosen by a control-mode input. In pin mode it is a dedicated pin. In register mode it is a bit from a control register, and the pin is ignored. In register mode the block comes out of reset silent. It stays silent until software sets the register bit and then clears it again.

The gained samples leave on a one-cycle output strobe. A flag reports when the gain applied to the samples has reached exactly zero.

Top module: `softMuteRamp`

## Requirements
- R1: While reset is held (synchronous, active low), and on the first cycle after it, `outLeft` and `outRight` are 0 and `outStb` is 0. `fullyMuted` equals the value of `regMode` during reset.
- R2: The mute request is selected by `regMode`. When `regMode`=0 the request is `mutePin`. When `regMode`=1 the request is `muteBit`, and `mutePin` has no effect on the outputs.
- R3: If reset is released with `regMode`=1, the block treats the mute as requested until `muteBit` is seen high and then low on the next cycle. Until that happens, every output sample is zero, even when `muteBit` is 0.
- R4: The gain at step k (k=0..32) is round(32768·(1+cos(πk/32))/2), an unsigned 16-bit value in which 32768 means unity. Each output is round(s·g/32768), with halves rounded toward +∞, and is saturated to 24-bit signed.
- R5: The block counts the strobes that arrive while it is not at rest in the requested direction. Every 32nd such strobe moves the step index by one toward 32 (mute) or toward 0 (unmute). Starting from rest, the output of the 1025th strobe is the first one produced with zero gain.
- R6: When the request reverses in the middle of a ramp, the step index is kept and the strobe count restarts. The next step, now in the new direction, comes 32 strobes later.
- R7: `fullyMuted` is updated with each output sample. It is 1 exactly when that sample was produced with zero gain, and it holds its value between strobes.
- R8: `outStb` follows `sampleStb` by one cycle. Both channels of a sample use the same gain. The gain changes only in the cycle after a strobe, and the outputs hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| sampleStb | input | 1 | Qualifies one stereo input sample |
| inLeft | input | 24 | Left input sample, signed |
| inRight | input | 24 | Right input sample, signed |
| mutePin | input | 1 | Mute request in pin mode |
| muteBit | input | 1 | Mute request in register mode |
| regMode | input | 1 | 1 selects register mode, 0 selects pin mode |
| outLeft | output | 24 | Gained left sample, signed |
| outRight | output | 24 | Gained right sample, signed |
| outStb | output | 1 | Output sample valid, one cycle after `sampleStb` |
| fullyMuted | output | 1 | The last output sample was produced with zero gain |

## Verification
Each sample result appears one clock after its input strobe. The sample is scaled by the gain that was in force before that strobe moved the step index, so a step change first shows up on the following strobe. The bench model advances at every rising edge using that same rule, and all outputs are compared at the falling edge that follows. Directed checks pick out the 1024th and 1025th strobes of a fade, the reversal midway through a fade, and the register-mode start-up, and each is read one cycle after its final strobe.

// File: rtl/softMutePkg.sv
package softMutePkg;
  localparam int GAIN_W = 16;

  typedef struct packed {
    logic              sampleStb;
    logic [GAIN_W-1:0] gain;
  } ctrlToPath_t;
endpackage

// File: rtl/softMuteCtrl.sv
module softMuteCtrl
  import softMutePkg::*;
#(
  parameter int STEPS  = 32,
  parameter int HOLD   = 32,
  parameter int STEP_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic              mutePin,
  input  logic              muteBit,
  input  logic              regMode,
  output logic [STEP_W-1:0] stepIdx,
  output ctrlToPath_t       toPath
);
  localparam int    CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int    UNITY = 1 << (GAIN_W - 1);
  localparam real   PI    = 3.14159265358979;

  function automatic logic [GAIN_W-1:0] cosGain(input int k);
    real x;
    x = (1.0 + $cos(PI * k / STEPS)) * UNITY / 2.0;
    return GAIN_W'($rtoi(x + 0.5));
  endfunction

  logic [GAIN_W-1:0] gainLut [STEPS+1];

  for (genvar k = 0; k <= STEPS; k++) begin : g_lut
    localparam logic [GAIN_W-1:0] G = cosGain(k);
    assign gainLut[k] = G;
  end

  logic             startHold;
  logic             muteBitQ;
  logic             dirMute;
  logic [CNT_W-1:0] holdCnt;
  logic             wantMute;
  logic             atRest;
  logic [CNT_W-1:0] baseCnt;

  assign wantMute = regMode ? (muteBit | startHold) : mutePin;
  assign atRest   = wantMute ? (stepIdx == STEP_W'(STEPS)) : (stepIdx == '0);
  assign baseCnt  = (wantMute != dirMute) ? '0 : holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startHold <= 1'b1;
      muteBitQ  <= 1'b0;
      dirMute   <= regMode;
      holdCnt   <= '0;
      stepIdx   <= regMode ? STEP_W'(STEPS) : '0;
    end else begin
      muteBitQ <= muteBit;
      if (regMode && muteBitQ && !muteBit) startHold <= 1'b0;
      if (sampleStb) begin
        dirMute <= wantMute;
        if (atRest) begin
          holdCnt <= '0;
        end else if (baseCnt == CNT_W'(HOLD - 1)) begin
          holdCnt <= '0;
          stepIdx <= wantMute ? stepIdx + 1'b1 : stepIdx - 1'b1;
        end else begin
          holdCnt <= baseCnt + 1'b1;
        end
      end
    end
  end

  assign toPath.sampleStb = sampleStb;
  assign toPath.gain      = gainLut[stepIdx];
endmodule

// File: rtl/softMutePath.sv
module softMutePath
  import softMutePkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regMode,
  input  ctrlToPath_t                fromCtrl,
  input  logic signed [SAMPLE_W-1:0] inLeft,
  input  logic signed [SAMPLE_W-1:0] inRight,
  output logic signed [SAMPLE_W-1:0] outLeft,
  output logic signed [SAMPLE_W-1:0] outRight,
  output logic                       outStb,
  output logic                       fullyMuted
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;
  localparam int SH = GAIN_W - 1;
  localparam logic signed [PW-1:0] RND  = PW'(1) << (SH - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) << (SAMPLE_W - 1));

  function automatic logic signed [SAMPLE_W-1:0] scale(
    input logic signed [SAMPLE_W-1:0] s,
    input logic [GAIN_W-1:0]          g
  );
    logic signed [PW-1:0] p;
    p = (PW'(s) * $signed({1'b0, g}) + RND) >>> SH;
    if (p > MAXV)      return MAXV[SAMPLE_W-1:0];
    else if (p < MINV) return MINV[SAMPLE_W-1:0];
    else               return p[SAMPLE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLeft    <= '0;
      outRight   <= '0;
      outStb     <= 1'b0;
      fullyMuted <= regMode;
    end else begin
      outStb <= fromCtrl.sampleStb;
      if (fromCtrl.sampleStb) begin
        outLeft    <= scale(inLeft, fromCtrl.gain);
        outRight   <= scale(inRight, fromCtrl.gain);
        fullyMuted <= (fromCtrl.gain == '0);
      end
    end
  end
endmodule

// File: rtl/softMuteRamp.sv
module softMuteRamp
  import softMutePkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int STEPS    = 32,
  parameter int HOLD     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleStb,
  input  logic signed [SAMPLE_W-1:0] inLeft,
  input  logic signed [SAMPLE_W-1:0] inRight,
  input  logic                       mutePin,
  input  logic                       muteBit,
  input  logic                       regMode,
  output logic signed [SAMPLE_W-1:0] outLeft,
  output logic signed [SAMPLE_W-1:0] outRight,
  output logic                       outStb,
  output logic                       fullyMuted
);
  localparam int STEP_W = $clog2(STEPS + 1);

  logic [STEP_W-1:0] stepIdx;
  ctrlToPath_t       ctrl2path;
  logic [GAIN_W-1:0] pathGain;

  assign pathGain = ctrl2path.gain;

  softMuteCtrl #(.STEPS(STEPS), .HOLD(HOLD), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .mutePin(mutePin),
    .muteBit(muteBit), .regMode(regMode), .stepIdx(stepIdx), .toPath(ctrl2path)
  );

  softMutePath #(.SAMPLE_W(SAMPLE_W)) u_path (
    .clk(clk), .rstN(rstN), .regMode(regMode), .fromCtrl(ctrl2path),
    .inLeft(inLeft), .inRight(inRight), .outLeft(outLeft), .outRight(outRight),
    .outStb(outStb), .fullyMuted(fullyMuted)
  );
endmodule

// File: rtl/softMuteChecker.sv
module softMuteChecker #(
  parameter int SAMPLE_W = 24,
  parameter int STEPS    = 32,
  parameter int STEP_W   = 6,
  parameter int GAIN_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                regMode,
  input logic                sampleStb,
  input logic                outStb,
  input logic                fullyMuted,
  input logic [SAMPLE_W-1:0] outLeft,
  input logic [SAMPLE_W-1:0] outRight,
  input logic [STEP_W-1:0]   stepIdx,
  input logic [GAIN_W-1:0]   pathGain
);
  AST_STB_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    outStb == $past(sampleStb)); // R8
  AST_GAIN_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(pathGain)); // R8
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= STEP_W'(STEPS)); // R5
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx == $past(stepIdx)) || (stepIdx == $past(stepIdx) + 1'b1)
    || (stepIdx == $past(stepIdx) - 1'b1)); // R6
  AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outStb && fullyMuted |-> (outLeft == '0) && (outRight == '0)); // R7
  AST_REG_START_MUTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) && $past(regMode) |-> fullyMuted); // R3
endmodule

bind softMuteRamp softMuteChecker #(
  .SAMPLE_W(SAMPLE_W), .STEPS(STEPS), .STEP_W(STEP_W), .GAIN_W(softMutePkg::GAIN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regMode(regMode), .sampleStb(sampleStb),
  .outStb(outStb), .fullyMuted(fullyMuted), .outLeft(outLeft),
  .outRight(outRight), .stepIdx(stepIdx), .pathGain(pathGain)
);

// File: tb/tb_softMuteRamp.sv
module tb_softMuteRamp;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic signed [23:0] inLeft = '0;
  logic signed [23:0] inRight = '0;
  logic mutePin = 1'b0, muteBit = 1'b0, regMode = 1'b0;
  logic signed [23:0] outLeft, outRight;
  logic outStb, fullyMuted;

  int checks = 0;
  int errors = 0;
  int sampleNo = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  softMuteRamp dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .inLeft(inLeft),
    .inRight(inRight), .mutePin(mutePin), .muteBit(muteBit), .regMode(regMode),
    .outLeft(outLeft), .outRight(outRight), .outStb(outStb), .fullyMuted(fullyMuted)
  );

  // reference model state
  int mK, mCnt;
  bit mDir, mHold, mBitQ;
  longint expL, expR;
  bit expStb, expMuted;

  function automatic longint gainRef(input int k);
    real x;
    x = (1.0 + $cos(3.14159265358979 * k / 32.0)) * 32768.0 / 2.0;
    return longint'($rtoi(x + 0.5));
  endfunction

  function automatic longint scaleRef(input longint s, input longint g);
    longint p;
    p = (s * g + 16384) >>> 15;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  always @(posedge clk) begin
    bit want, rest;
    int base;
    if (!rstN) begin
      mK = regMode ? 32 : 0; mCnt = 0; mDir = regMode; mHold = 1; mBitQ = 0;
      expL = 0; expR = 0; expStb = 0; expMuted = regMode;
    end else begin
      want = regMode ? (muteBit || mHold) : mutePin;
      if (regMode && mBitQ && !muteBit) mHold = 0;
      mBitQ = muteBit;
      expStb = sampleStb;
      if (sampleStb) begin
        expL = scaleRef(longint'(inLeft), gainRef(mK));
        expR = scaleRef(longint'(inRight), gainRef(mK));
        expMuted = (gainRef(mK) == 0);
        rest = want ? (mK == 32) : (mK == 0);
        base = (want != mDir) ? 0 : mCnt;
        mDir = want;
        if (rest) mCnt = 0;
        else if (base == 31) begin mCnt = 0; mK = want ? mK + 1 : mK - 1; end
        else mCnt = base + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(longint'(outLeft) == expL && longint'(outRight) == expR, "R4 samples",
            longint'(outLeft), expL);
      check(outStb == expStb, "R8 outStb", outStb, expStb);
      check(fullyMuted == expMuted, "R7 fullyMuted", fullyMuted, expMuted);
    end
  end

  task automatic doReset(input bit mode);
    @(negedge clk);
    rstN = 1'b0; regMode = mode; sampleStb = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      sampleNo++;
      if (sampleNo % 16 == 0) begin
        inLeft = 24'sh7FFFFF; inRight = 24'sh800000;
      end else begin
        inLeft  = 24'(sampleNo * 104729 + 12345);
        inRight = 24'(~(sampleNo * 7919));
      end
      sampleStb = 1'b1;
      @(negedge clk);
      sampleStb = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, pin mode
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outLeft == 0 && outRight == 0 && !outStb, "R1 outputs in reset", outLeft, 0);
    check(fullyMuted == 1'b0, "R1 fullyMuted pin mode in reset", fullyMuted, 0);
    doReset(1'b0);
    check(outLeft == 0 && outRight == 0 && !outStb, "R1 outputs after reset", outLeft, 0);
    check(fullyMuted == 1'b0, "R1 fullyMuted pin mode", fullyMuted, 0);

    // unity pass-through, R4
    strobes(40);
    check(longint'(outLeft) == expL, "R4 unity gain", outLeft, expL);

    // R5: full fade timing in pin mode (R2 pin drives request)
    mutePin = 1'b1;
    strobes(1024);
    check(fullyMuted == 1'b0, "R5 not muted after 1024", fullyMuted, 0);
    strobes(1);
    check(fullyMuted == 1'b1, "R5 muted after 1025", fullyMuted, 1);
    check(outLeft == 0 && outRight == 0, "R7 zero output", outLeft, 0);
    strobes(30);

    // R6: reverse mid-ramp
    mutePin = 1'b0;
    strobes(500);
    check(fullyMuted == 1'b0, "R6 unmuting", fullyMuted, 0);
    mutePin = 1'b1;
    strobes(300);
    mutePin = 1'b0;
    strobes(17);
    mutePin = 1'b1;
    strobes(800);
    check(fullyMuted == 1'b1, "R6 muted after reversals", fullyMuted, 1);

    // R1 / R3: register mode start-up
    mutePin = 1'b0; muteBit = 1'b0;
    doReset(1'b1);
    check(fullyMuted == 1'b1, "R1 fullyMuted register mode", fullyMuted, 1);
    strobes(100);
    check(fullyMuted == 1'b1 && outLeft == 0, "R3 held muted with bit low", outLeft, 0);
    mutePin = 1'b1; strobes(20); mutePin = 1'b0; strobes(20);
    check(fullyMuted == 1'b1, "R2 pin ignored in register mode", fullyMuted, 1);
    muteBit = 1'b1; strobes(3);
    muteBit = 1'b0;
    strobes(1100);
    check(fullyMuted == 1'b0 && longint'(outLeft) == expL, "R3 released after set-clear",
          outLeft, expL);

    // R2: pin ignored while unmuted in register mode
    mutePin = 1'b1;
    strobes(200);
    check(fullyMuted == 1'b0, "R2 pin no effect", fullyMuted, 0);
    check(longint'(outRight) == expR, "R2 output unchanged", outRight, expR);

    // register bit mutes
    muteBit = 1'b1;
    strobes(1030);
    check(fullyMuted == 1'b1, "R2 bit mutes", fullyMuted, 1);

    // R8: outputs hold between strobes
    repeat (5) @(negedge clk);
    check(!outStb && outLeft == 0, "R8 hold between strobes", outStb, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule